// File: doc/BRIEF.md
# Serial-Load Output Expander with Holding Latch

The block is a serial-in, parallel-out register with an output latch. A serial bit stream is clocked into a chain of shift stages on one clock. A second, independent clock copies the whole chain into a holding latch in a single step. The parallel outputs are taken from the holding latch, so the visible pattern only changes when the latch clock fires. Loading a new pattern therefore never makes the outputs flicker.

A typical use is as an output expander behind an SPI master. The serial clock drives the shift clock, the data line drives the serial input, and the rising edge at chip-select release drives the latch clock. The last shift stage is brought out as a cascade output, so several expanders can share the clocks and form a longer chain.

The parallel pins are three-state. They are modelled as a data vector plus a per-bit drive-enable vector, where a drive value of zero stands for high impedance. An active-low asynchronous reset clears only the shift stages. The holding latch has no reset and starts at zero.

Top module: `sipo_latch_expander`

## Requirements
- R1: On each rising edge of `shift_clk`, `ser_in` enters stage 0 and every stage moves one position toward stage WIDTH-1. A bit therefore reaches `ser_out` after exactly WIDTH edges.
- R2: On each rising edge of `latch_clk`, all WIDTH shift stages are copied into the holding latch. After WIDTH edges of `shift_clk`, `par_data` equals the bit sent first at position WIDTH-1 and the bit sent last at position 0.
- R3: `par_data` changes only on a rising edge of `latch_clk`. Edges of `shift_clk` between latch edges leave it unchanged.
- R4: While `rst_n` is low, the shift stages are cleared and `ser_out` is 0, regardless of the clocks. The holding latch and `par_data` keep their values through the reset.
- R5: When `oe_n` is low, every bit of `par_drive` is 1. When `oe_n` is high, every bit of `par_drive` is 0, meaning high impedance. `oe_n` has no effect on `par_data`.
- R6: `ser_out` always shows shift stage WIDTH-1 and is not affected by `oe_n`. With two devices chained ser_out-to-ser_in on shared clocks, 2*WIDTH shifts and one latch edge leave the first-sent WIDTH bits in the downstream device.
- R7: When `shift_clk` and `latch_clk` rise together, the latch captures the shift-stage contents from before that shift edge.
- R8: Before its first `latch_clk` edge, the holding latch reads all zeros on `par_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shift_clk | input | 1 | Shift clock; rising edge moves the chain |
| latch_clk | input | 1 | Latch clock; rising edge copies the chain to the outputs |
| rst_n | input | 1 | Asynchronous active-low clear of the shift stages only |
| oe_n | input | 1 | Active-low output enable for the parallel pins |
| ser_in | input | 1 | Serial data into stage 0 |
| par_data | output | WIDTH | Holding latch contents |
| par_drive | output | WIDTH | Per-bit drive enable; 0 means high impedance |
| ser_out | output | 1 | Cascade output, last shift stage |

## Verification
The assertions run on every cycle and cover four properties. The drive vector is either all on or all off, and it follows the enable. The latched value matches the chain as it stood at the previous latch edge. The parallel value holds steady across shift edges when no latch edge occurs between them. The cascade output trails the next-to-last stage by one shift edge, and both the chain and the cascade read zero during reset. Some behaviours can only be shown by the bench's scenarios, because they depend on a specific stimulus order. These are the full sweep of all 256 byte patterns, the cascade of two devices, the ordering when both clocks rise together, and the check that a reset between shifting and latching leaves the outputs alone.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    parameter int SIPO_DEF_WIDTH = 8;

    typedef enum logic {
        DRIVE_OFF = 1'b0,
        DRIVE_ON  = 1'b1
    } drive_e;

    function automatic drive_e drive_mode(input logic enable_n);
        return enable_n ? DRIVE_OFF : DRIVE_ON;
    endfunction
endpackage

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         din,
    output logic [W-1:0] q
);
    // Stage 0 takes the new bit; older bits move toward stage W-1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= {q[W-2:0], din};
        end
    end
endmodule

// File: rtl/sipo_hold_latch.sv
module sipo_hold_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // No reset on purpose: the shift-stage clear must not reach here.
    logic [W-1:0] hold_q = '0;

    always_ff @(posedge clk) begin
        hold_q <= d;
    end

    assign q = hold_q;
endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate #(
    parameter int W = 8
) (
    input  logic         oe_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] data_o,
    output logic [W-1:0] drive_o
);
    import sipo_pkg::*;

    drive_e mode;
    assign mode = drive_mode(oe_n);

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign data_o[i]  = d[i];
        assign drive_o[i] = (mode == DRIVE_ON);
    end
endmodule

// File: rtl/sipo_latch_expander.sv
module sipo_latch_expander #(
    parameter int WIDTH = sipo_pkg::SIPO_DEF_WIDTH
) (
    input  logic             shift_clk,
    input  logic             latch_clk,
    input  logic             rst_n,
    input  logic             oe_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] par_data,
    output logic [WIDTH-1:0] par_drive,
    output logic             ser_out
);
    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] shift_q;
    logic [WIDTH-1:0] hold_q;

    sipo_shift_stage #(.W(WIDTH)) u_shift (
        .clk   (shift_clk),
        .rst_n (rst_n),
        .din   (ser_in),
        .q     (shift_q)
    );

    sipo_hold_latch #(.W(WIDTH)) u_hold (
        .clk (latch_clk),
        .d   (shift_q),
        .q   (hold_q)
    );

    sipo_out_gate #(.W(WIDTH)) u_gate (
        .oe_n    (oe_n),
        .d       (hold_q),
        .data_o  (par_data),
        .drive_o (par_drive)
    );

    assign ser_out = shift_q[LAST];
endmodule

// File: rtl/sipo_latch_expander_chk.sv
module sipo_latch_expander_chk #(
    parameter int W = 8
) (
    input logic         shift_clk,
    input logic         latch_clk,
    input logic         rst_n,
    input logic         oe_n,
    input logic [W-1:0] shift_q,
    input logic [W-1:0] par_data,
    input logic [W-1:0] par_drive,
    input logic         ser_out
);
    logic rst_ok  = 1'b0;
    logic lck_tog = 1'b0;
    logic lck_seen = 1'b0;

    always_ff @(posedge shift_clk or negedge rst_n) begin
        if (!rst_n) rst_ok <= 1'b0;
        else        rst_ok <= 1'b1;
    end

    always_ff @(posedge latch_clk) begin
        lck_tog  <= ~lck_tog;
        lck_seen <= 1'b1;
    end

    // R5: all pins share one drive state
    always_comb begin
        p_drive_uniform_r5: assert ($countones(par_drive) == 0 || $countones(par_drive) == W)
            else $error("drive vector split");
    end

    p_drive_on_r5: assert property (@(posedge latch_clk) disable iff (!rst_n)
        !oe_n |-> (par_drive == {W{1'b1}}))
        else $error("drive not on while enabled");

    p_latch_copy_r2: assert property (@(posedge latch_clk) disable iff (!rst_n)
        lck_seen |-> (par_data == $past(shift_q)))
        else $error("latch did not take chain value");

    p_hold_stable_r3: assert property (@(posedge shift_clk) disable iff (!rst_n)
        (rst_ok && lck_tog == $past(lck_tog)) |-> $stable(par_data))
        else $error("parallel data moved without latch edge");

    p_cascade_r6: assert property (@(posedge shift_clk) disable iff (!rst_n)
        rst_ok |-> (ser_out == $past(shift_q[W-2])))
        else $error("cascade output out of step");

    p_reset_clear_r4: assert property (@(posedge shift_clk) disable iff (rst_n)
        1'b1 |-> (ser_out == 1'b0 && shift_q == '0))
        else $error("chain not clear in reset");
endmodule

bind sipo_latch_expander sipo_latch_expander_chk #(.W(WIDTH)) u_chk (
    .shift_clk (shift_clk),
    .latch_clk (latch_clk),
    .rst_n     (rst_n),
    .oe_n      (oe_n),
    .shift_q   (shift_q),
    .par_data  (par_data),
    .par_drive (par_drive),
    .ser_out   (ser_out)
);

// File: tb/sipo_latch_expander_test.sv
module sipo_latch_expander_test;
    localparam int W = 8;

    logic clk = 1'b0;
    logic sck = 1'b0;
    logic lck = 1'b0;
    logic rst_n = 1'b0;
    logic oe_n = 1'b1;
    logic din = 1'b0;
    logic done = 1'b0;

    logic [W-1:0] pd1, pdrv1, pd2, pdrv2;
    logic so1, so2;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    sipo_latch_expander #(.WIDTH(W)) uut (
        .shift_clk (sck), .latch_clk (lck), .rst_n (rst_n), .oe_n (oe_n),
        .ser_in (din), .par_data (pd1), .par_drive (pdrv1), .ser_out (so1)
    );

    sipo_latch_expander #(.WIDTH(W)) uut2 (
        .shift_clk (sck), .latch_clk (lck), .rst_n (rst_n), .oe_n (oe_n),
        .ser_in (so1), .par_data (pd2), .par_drive (pdrv2), .ser_out (so2)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_sck(input logic b);
        din = b; #1; sck = 1'b1; #2; sck = 1'b0; #1;
    endtask

    task automatic pulse_lck();
        #1; lck = 1'b1; #2; lck = 1'b0; #1;
    endtask

    task automatic shift_word(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse_sck(v[i]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; #3; rst_n = 1'b1; #1;
    endtask

    initial begin
        logic [W-1:0] prev;
        logic [15:0]  pats [4];
        pats[0] = 16'hA55A; pats[1] = 16'h0001; pats[2] = 16'h8000; pats[3] = 16'h1234;

        #10;
        chk("R8 latch starts at zero", pd1, 0);
        chk("R4 cascade zero in reset", so1, 0);
        chk("R5 outputs off when oe_n high", pdrv1, 0);
        rst_n = 1'b1; #4;

        // R1: a single one travels to the cascade in exactly W shifts
        pulse_sck(1'b1);
        for (int i = 1; i < W; i++) pulse_sck(1'b0);
        chk("R1 bit at last stage after W shifts", so1, 1);
        pulse_sck(1'b0);
        chk("R1 bit leaves after W+1 shifts", so1, 0);
        do_reset();

        oe_n = 1'b0; #1;
        chk("R5 outputs driven when oe_n low", pdrv1, 8'hFF);

        prev = '0;
        for (int v = 0; v < 256; v++) begin
            shift_word(16'(v), W);
            chk("R3 shifting leaves outputs", pd1, prev);
            chk("R1 first bit at cascade", so1, v[W-1]);
            pulse_lck();
            chk("R2 latch copies chain", pd1, v);
            prev = W'(v);
        end

        oe_n = 1'b1; #1;
        chk("R5 off state hides drive", pdrv1, 0);
        chk("R5 data unaffected by oe_n", pd1, prev);
        chk("R6 cascade unaffected by oe_n", so1, prev[W-1]);
        oe_n = 1'b0; #1;
        chk("R5 back on", pdrv1, 8'hFF);

        // R4: reset between shift and latch
        shift_word(16'h005A, W);
        rst_n = 1'b0; #2;
        chk("R4 cascade cleared", so1, 0);
        chk("R4 latch kept through reset", pd1, prev);
        rst_n = 1'b1; #2;
        chk("R4 latch still kept after release", pd1, prev);
        pulse_lck();
        chk("R4 chain was cleared", pd1, 0);

        // R7: coincident edges take the pre-shift chain
        shift_word(16'h00C3, W);
        din = 1'b0; #1;
        sck = 1'b1; lck = 1'b1; #2;
        sck = 1'b0; lck = 1'b0; #1;
        chk("R7 coincident latch gets old chain", pd1, 8'hC3);
        pulse_lck();
        chk("R7 shift still happened", pd1, 8'h86);

        // R6: two devices in cascade
        foreach (pats[k]) begin
            do_reset();
            shift_word(pats[k], 2 * W);
            pulse_lck();
            chk("R6 downstream holds first byte", pd2, pats[k][15:8]);
            chk("R6 upstream holds last byte", pd1, pats[k][7:0]);
            chk("R6 downstream cascade", so2, pats[k][15]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule